// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block sequences a 12-bit successive-approximation analog-to-digital conversion. It is built around a register-style control surface. Software picks one of eight analog inputs and picks a conversion-clock prescale. It then starts a conversion by writing a start bit. A timer event or an event-counter event, chosen by a trigger-select field, can start a conversion in the same way. A standby control shuts the converter down.

Once started, the block raises a sample-and-hold strobe for a fixed setup interval of conversion-clock ticks. It then resolves the code one bit at a time, from the most significant bit downward. For each bit it drives a 12-bit trial code to an external DAC and comparator, and it samples the comparator's one-bit answer. When the least significant bit is settled, the code is loaded into a pair of 8-bit result registers. At the same time a done flag is set and a one-cycle interrupt pulse is produced in the system clock domain.

The comparator, DAC and sample-and-hold circuit are not part of the block. Port direction control for the analog pins is also outside it.

Top module: `adc_sar_sequencer`

## Requirements
- R1: With a comparator that reports 1 when the selected input is at or above the trial code, the result is the largest 12-bit code not above the input, that is min(input, 4095). Each bit is decided from the MSB down to the LSB, and a comparator 1 keeps the trial bit.
- R2: On the cycle a conversion begins, the three low bits of the 4-bit channel field are latched onto `amux_sel`; bit 3 of the field is ignored. `amux_sel` holds for the rest of the conversion, even if the channel field changes.
- R3: A write strobe on `start_wr` sets `start_bit` after that clock edge. On the next edge the conversion begins: `start_bit` returns to 0 and `busy` goes to 1.
- R4: A conversion lasts 60 conversion ticks. The first 12 ticks are setup, during which `sh_sample` is 1 and `dac_code` is 0. With a prescale of N system clocks per tick, `done_flag` and `irq` are 1 exactly 60·N + 2 cycles after the edge that sampled the start request.
- R5: `done_flag` is 0 from the cycle a conversion begins until that conversion's result is loaded.
- R6: `res_hi` holds result bits 11..4. `res_lo` holds result bits 3..0 in its upper nibble, with zeros in its lower nibble. A `res_lo_rd` strobe clears `done_flag`. Starting a new conversion also clears it.
- R7: `irq` is a single-cycle pulse that occurs in the cycle in which `done_flag` first reads 1.
- R8: While `standby` is 1, start requests are ignored. A conversion already running is aborted within one cycle. The abort raises neither `done_flag` nor `irq`, and the result registers keep their old value.
- R9: `psc_sel` values 0, 1, 2 and 3 give 2, 4, 8 and 16 system clocks per conversion tick.
- R10: `trig_sel` = 1 lets a `timer_evt` pulse start a conversion, and `trig_sel` = 2 lets a `count_evt` pulse do the same. Values 0 and 3 disable both. A pulse from the source that is not selected has no effect.
- R11: A start request made while `busy` is 1 is ignored. `start_bit` stays 0, the running result is unchanged, and no second conversion follows.
- R12: Each bit takes four ticks. The trial bit is raised on the first tick, the comparator is sampled on the third tick, and the bit is kept or cleared on the fourth tick. The MSB trial therefore appears on tick 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 4 | Channel field; the low three bits select the input |
| start_wr | input | 1 | Strobe that writes 1 to the start bit |
| standby | input | 1 | Power-down; disables the converter |
| trig_sel | input | 2 | Hardware trigger source: 0 none, 1 timer, 2 counter, 3 none |
| timer_evt | input | 1 | Timer event pulse |
| count_evt | input | 1 | Event-counter pulse |
| psc_sel | input | 2 | Conversion-clock prescale select |
| res_lo_rd | input | 1 | Read strobe of the low result register |
| comp_in | input | 1 | Comparator result: 1 means input at or above the trial code |
| start_bit | output | 1 | Start bit readback |
| busy | output | 1 | Conversion in progress |
| sh_sample | output | 1 | Sample-and-hold strobe during setup |
| amux_sel | output | 3 | Analog multiplexer select |
| dac_code | output | 12 | Trial code driven to the DAC |
| res_hi | output | 8 | High result register |
| res_lo | output | 8 | Low result register |
| done_flag | output | 1 | Conversion-complete status |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Damage to the tick counter or the bit-phase counter shows first as timing. The sample strobe falls, or the MSB trial rises, on the wrong tick, which can be seen within 13 ticks of the start. The completion pulse then also arrives off the expected 60·N + 2 cycle mark. A wrong keep or clear decision, or a wrong sampling phase, leaves a result code that differs from the ideal min(input, 4095) for inputs chosen to make each bit matter. A corrupted start latch or status flag shows directly as one of three faults: the start bit failing to self-clear on the next edge, a spurious second completion pulse, or a flag that reads 1 while busy.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CONV  = 2'd2
  } sar_state_e;

  typedef enum logic [1:0] {
    TRG_NONE  = 2'd0,
    TRG_TIMER = 2'd1,
    TRG_COUNT = 2'd2,
    TRG_RSVD  = 2'd3
  } trg_sel_e;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int PSC_W = 2,
  localparam int CNT_W = 2 ** PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_sel,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  // limit = 2^(psc_sel+1) - 1, built as a run of ones
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      limit[i] = (i <= int'(psc_sel));
    end
  end

  assign tick = run && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (run) begin
      if (tick) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R9

endmodule

// File: rtl/sar_start_ctl.sv
module sar_start_ctl
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_wr,
  input  logic [1:0] trig_sel,
  input  logic       timer_evt,
  input  logic       count_evt,
  input  logic       standby,
  input  logic       busy,
  output logic       start_bit,
  output logic       begin_conv
);

  logic start_q, start_d;
  logic hw_req, any_req;

  always_comb begin
    hw_req = 1'b0;
    case (trg_sel_e'(trig_sel))
      TRG_TIMER: hw_req = timer_evt;
      TRG_COUNT: hw_req = count_evt;
      default:   hw_req = 1'b0;
    endcase
    any_req = start_wr | hw_req;
  end

  // Start bit lives for one cycle: set when idle, cleared as conversion begins
  always_comb begin
    start_d = 1'b0;
    if (!standby && !start_q && !busy && any_req) start_d = 1'b1;
  end

  assign begin_conv = start_q && !standby;
  assign start_bit  = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R3
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !busy); // R11
  AST_STBY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !start_q); // R8

endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SETUP_TICKS = 12,
  parameter int STEPS       = 4,
  parameter int CHAN_W      = 4,
  parameter int NUM_CH      = 8,
  localparam int SEL_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_conv,
  input  logic              standby,
  input  logic              tick,
  input  logic [CHAN_W-1:0] chan_cfg,
  input  logic              comp_in,
  output logic              busy,
  output logic              sh_sample,
  output logic [SEL_W-1:0]  amux_sel,
  output logic [RES_W-1:0]  dac_code,
  output logic              fin
);

  localparam int SC_W = $clog2(SETUP_TICKS);
  localparam int PH_W = $clog2(STEPS);
  localparam int BI_W = $clog2(RES_W);
  localparam logic [SC_W-1:0] SETUP_LAST = SC_W'(SETUP_TICKS - 1);
  localparam logic [PH_W-1:0] PH_TRIAL   = '0;
  localparam logic [PH_W-1:0] PH_SAMPLE  = PH_W'(STEPS - 2);
  localparam logic [PH_W-1:0] PH_DECIDE  = PH_W'(STEPS - 1);
  localparam logic [BI_W-1:0] BIT_TOP    = BI_W'(RES_W - 1);

  sar_state_e       state_q, state_d;
  logic [SC_W-1:0]  setup_q, setup_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [BI_W-1:0]  bit_q, bit_d;
  logic [RES_W-1:0] sar_q, sar_d;
  logic [SEL_W-1:0] chan_q, chan_d;
  logic             cmp_q, cmp_d;
  logic             fin_q, fin_d;

  always_comb begin
    state_d = state_q;
    setup_d = setup_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    sar_d   = sar_q;
    chan_d  = chan_q;
    cmp_d   = cmp_q;
    fin_d   = 1'b0;
    if (standby) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (begin_conv) begin
            state_d = ST_SETUP;
            setup_d = '0;
            sar_d   = '0;
            chan_d  = chan_cfg[SEL_W-1:0];
          end
        end
        ST_SETUP: begin
          if (tick) begin
            if (setup_q == SETUP_LAST) begin
              state_d = ST_CONV;
              phase_d = PH_TRIAL;
              bit_d   = BIT_TOP;
            end else begin
              setup_d = setup_q + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (tick) begin
            phase_d = (phase_q == PH_DECIDE) ? PH_TRIAL : phase_q + 1'b1;
            if (phase_q == PH_TRIAL) begin
              sar_d[bit_q] = 1'b1;
            end
            if (phase_q == PH_SAMPLE) begin
              cmp_d = comp_in;
            end
            if (phase_q == PH_DECIDE) begin
              if (!cmp_q) sar_d[bit_q] = 1'b0;
              if (bit_q == '0) begin
                state_d = ST_IDLE;
                fin_d   = 1'b1;
              end else begin
                bit_d = bit_q - 1'b1;
              end
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      setup_q <= '0;
      phase_q <= '0;
      bit_q   <= '0;
      sar_q   <= '0;
      chan_q  <= '0;
      cmp_q   <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      setup_q <= setup_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sar_q   <= sar_d;
      chan_q  <= chan_d;
      cmp_q   <= cmp_d;
      fin_q   <= fin_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign sh_sample = (state_q == ST_SETUP);
  assign amux_sel  = chan_q;
  assign dac_code  = sar_q;
  assign fin       = fin_q;

  AST_SETUP_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sh_sample |-> (dac_code == '0)); // R4
  AST_STBY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !busy); // R8
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(amux_sel)); // R2
  AST_FIN_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ($past(busy) && !busy)); // R4

endmodule

// File: rtl/sar_result_regs.sv
module sar_result_regs #(
  parameter int RES_W = 12,
  parameter int REG_W = 8,
  localparam int LO_BITS = RES_W - REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  logic [RES_W-1:0] result_in,
  input  logic             begin_conv,
  input  logic             rd_lo,
  input  logic             busy,
  output logic [REG_W-1:0] res_hi,
  output logic [REG_W-1:0] res_lo,
  output logic             done_flag,
  output logic             irq
);

  logic [RES_W-1:0] res_q, res_d;
  logic             flag_q, flag_d;
  logic             irq_q;

  always_comb begin
    res_d  = res_q;
    flag_d = flag_q;
    if (fin) begin
      res_d  = result_in;
      flag_d = 1'b1;
    end else if (begin_conv || rd_lo) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      flag_q <= flag_d;
      irq_q  <= fin;
    end
  end

  assign res_hi = res_q[RES_W-1 -: REG_W];

  generate
    if (LO_BITS == REG_W) begin : g_lo_full
      assign res_lo = res_q[REG_W-1:0];
    end else begin : g_lo_pad
      assign res_lo = {res_q[LO_BITS-1:0], {(REG_W - LO_BITS){1'b0}}};
    end
  endgenerate

  assign done_flag = flag_q;
  assign irq       = irq_q;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag); // R7
  AST_FLAG_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_flag); // R5

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer #(
  parameter int RES_W       = 12,
  parameter int SETUP_TICKS = 12,
  parameter int STEPS       = 4,
  parameter int CHAN_W      = 4,
  parameter int NUM_CH      = 8,
  parameter int PSC_W       = 2,
  parameter int REG_W       = 8,
  localparam int SEL_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] chan_sel,
  input  logic              start_wr,
  input  logic              standby,
  input  logic [1:0]        trig_sel,
  input  logic              timer_evt,
  input  logic              count_evt,
  input  logic [PSC_W-1:0]  psc_sel,
  input  logic              res_lo_rd,
  input  logic              comp_in,
  output logic              start_bit,
  output logic              busy,
  output logic              sh_sample,
  output logic [SEL_W-1:0]  amux_sel,
  output logic [RES_W-1:0]  dac_code,
  output logic [REG_W-1:0]  res_hi,
  output logic [REG_W-1:0]  res_lo,
  output logic              done_flag,
  output logic              irq
);

  // Reset: asserts asynchronously, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic begin_conv;
  logic tick;
  logic fin;

  sar_start_ctl u_start (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_wr   (start_wr),
    .trig_sel   (trig_sel),
    .timer_evt  (timer_evt),
    .count_evt  (count_evt),
    .standby    (standby),
    .busy       (busy),
    .start_bit  (start_bit),
    .begin_conv (begin_conv)
  );

  sar_tick_gen #(.PSC_W(PSC_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .restart (begin_conv),
    .run     (busy),
    .psc_sel (psc_sel),
    .tick    (tick)
  );

  sar_engine #(
    .RES_W       (RES_W),
    .SETUP_TICKS (SETUP_TICKS),
    .STEPS       (STEPS),
    .CHAN_W      (CHAN_W),
    .NUM_CH      (NUM_CH)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .begin_conv (begin_conv),
    .standby    (standby),
    .tick       (tick),
    .chan_cfg   (chan_sel),
    .comp_in    (comp_in),
    .busy       (busy),
    .sh_sample  (sh_sample),
    .amux_sel   (amux_sel),
    .dac_code   (dac_code),
    .fin        (fin)
  );

  sar_result_regs #(.RES_W(RES_W), .REG_W(REG_W)) u_result (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .fin        (fin),
    .result_in  (dac_code),
    .begin_conv (begin_conv),
    .rd_lo      (res_lo_rd),
    .busy       (busy),
    .res_hi     (res_hi),
    .res_lo     (res_lo),
    .done_flag  (done_flag),
    .irq        (irq)
  );

endmodule

// File: tb/adc_sar_sequencer_tb.sv
module adc_sar_sequencer_tb;

  logic        clk;
  logic        rst_n;
  logic [3:0]  chan_sel;
  logic        start_wr;
  logic        standby;
  logic [1:0]  trig_sel;
  logic        timer_evt;
  logic        count_evt;
  logic [1:0]  psc_sel;
  logic        res_lo_rd;
  logic        comp_in;
  logic        start_bit;
  logic        busy;
  logic        sh_sample;
  logic [2:0]  amux_sel;
  logic [11:0] dac_code;
  logic [7:0]  res_hi;
  logic [7:0]  res_lo;
  logic        done_flag;
  logic        irq;

  int vin [0:7];
  int cyc;
  int n_checks;
  int n_fail;

  typedef struct {
    int val;
    int at;
  } exp_t;
  exp_t sb_q[$];

  adc_sar_sequencer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_sel  (chan_sel),
    .start_wr  (start_wr),
    .standby   (standby),
    .trig_sel  (trig_sel),
    .timer_evt (timer_evt),
    .count_evt (count_evt),
    .psc_sel   (psc_sel),
    .res_lo_rd (res_lo_rd),
    .comp_in   (comp_in),
    .start_bit (start_bit),
    .busy      (busy),
    .sh_sample (sh_sample),
    .amux_sel  (amux_sel),
    .dac_code  (dac_code),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .done_flag (done_flag),
    .irq       (irq)
  );

  // Behavioural comparator: input at or above the trial code
  assign comp_in = (vin[amux_sel] >= int'(dac_code));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rd_result();
    return int'({res_hi, res_lo[7:4]});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) begin
      @(posedge clk);
      #1;
    end
  endtask

  // src: 0 software write, 1 timer event, 2 counter event
  task automatic start_pulse(input int src, output int e0);
    @(negedge clk);
    case (src)
      1:       timer_evt = 1'b1;
      2:       count_evt = 1'b1;
      default: start_wr  = 1'b1;
    endcase
    @(posedge clk);
    #1;
    e0 = cyc;
    start_wr  = 1'b0;
    timer_evt = 1'b0;
    count_evt = 1'b0;
  endtask

  // Driver: pushes expected item, checks timing, waits for the result
  task automatic run_conv(input int ch, input int psc, input int src, input bit timing);
    int n, e0, done_at, expv;
    exp_t it;
    n = 2 << psc;
    chan_sel = 4'(ch);
    psc_sel  = 2'(psc);
    expv = (vin[ch & 7] > 4095) ? 4095 : vin[ch & 7];
    start_pulse(src, e0);
    done_at = e0 + 60 * n + 2;
    it.val = expv;
    it.at  = done_at;
    sb_q.push_back(it);
    chk(start_bit == 1'b1, "R3 start bit set", int'(start_bit), 1);
    wait_to(e0 + 1);
    chk(start_bit == 1'b0 && busy == 1'b1, "R3 self-clear and busy", int'({start_bit, busy}), 1);
    chk(done_flag == 1'b0, "R5 flag low at begin", int'(done_flag), 0);
    chk(amux_sel == 3'(ch), "R2 channel latched", int'(amux_sel), ch & 7);
    if (timing) begin
      wait_to(e0 + 12 * n);
      chk(sh_sample == 1'b1 && dac_code == 12'd0, "R4 setup last tick", int'(sh_sample), 1);
      wait_to(e0 + 1 + 12 * n);
      chk(sh_sample == 1'b0, "R4 setup ends after 12 ticks", int'(sh_sample), 0);
      wait_to(e0 + 13 * n);
      chk(dac_code[11] == 1'b0, "R12 no trial before tick 13", int'(dac_code[11]), 0);
      wait_to(e0 + 1 + 13 * n);
      chk(dac_code[11] == 1'b1, "R12 MSB trial on tick 13", int'(dac_code[11]), 1);
      wait_to(e0 + 16 * n);
      chk(dac_code[11] == 1'b1, "R12 MSB held until tick 16", int'(dac_code[11]), 1);
      wait_to(e0 + 1 + 16 * n);
      chk(dac_code[11] == expv[11], "R12 MSB decided on tick 16", int'(dac_code[11]), expv >> 11);
      wait_to(done_at - 1);
      chk(done_flag == 1'b0, "R5 flag low before load", int'(done_flag), 0);
    end
    wait_to(done_at);
    chk(done_flag == 1'b1, "R4 flag at 60N+2", int'(done_flag), 1);
    chk(res_lo[3:0] == 4'd0, "R6 low nibble zero", int'(res_lo[3:0]), 0);
    chk(rd_result() == expv, "R6 register split", rd_result(), expv);
  endtask

  // Monitor: pops the scoreboard on each completion pulse
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (irq === 1'b1) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R11 unexpected completion", 1, 0);
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          chk(cyc == it.at, "R4 completion cycle", cyc, it.at);
          chk(rd_result() == it.val, "R1 conversion result", rd_result(), it.val);
          chk(done_flag == 1'b1, "R7 irq with flag", int'(done_flag), 1);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int e0, keep;
    n_checks = 0;
    n_fail   = 0;
    rst_n = 1'b0;
    chan_sel = '0; start_wr = 1'b0; standby = 1'b0; trig_sel = 2'd0;
    timer_evt = 1'b0; count_evt = 1'b0; psc_sel = 2'd0; res_lo_rd = 1'b0;
    vin[0] = 0;    vin[1] = 2049; vin[2] = 1;    vin[3] = 1234;
    vin[4] = 777;  vin[5] = 3000; vin[6] = 100;  vin[7] = 5000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(busy == 1'b0 && start_bit == 1'b0, "R3 reset idle", int'({busy, start_bit}), 0);
    chk(done_flag == 1'b0 && irq == 1'b0, "R7 reset no flag", int'({done_flag, irq}), 0);
    chk(res_hi == 8'd0 && res_lo == 8'd0, "R6 reset result", rd_result(), 0);

    // Main function with timing, prescale 2
    run_conv(3, 0, 0, 1'b1);
    @(negedge clk); res_lo_rd = 1'b1;
    @(posedge clk); #1; res_lo_rd = 1'b0;
    chk(done_flag == 1'b0, "R6 low read clears flag", int'(done_flag), 0);

    // Channel bit 3 ignored, other prescales
    run_conv(13, 1, 0, 1'b1);
    run_conv(0, 2, 0, 1'b0);
    run_conv(7, 3, 0, 1'b0);
    chk(rd_result() == 4095, "R1 saturates high input", rd_result(), 4095);

    // Hardware triggers
    trig_sel = 2'd1;
    run_conv(1, 0, 1, 1'b0);
    trig_sel = 2'd2;
    start_pulse(1, e0);
    chk(start_bit == 1'b0, "R10 unselected timer ignored", int'(start_bit), 0);
    wait_to(e0 + 1);
    chk(busy == 1'b0, "R10 no conversion from timer", int'(busy), 0);
    run_conv(2, 0, 2, 1'b0);
    trig_sel = 2'd0;

    // Start while busy is ignored; channel change does not disturb
    fork
      run_conv(4, 0, 0, 1'b0);
      begin
        repeat (40) @(posedge clk);
        #1;
        chan_sel = 4'd7;
        start_pulse(0, e0);
        chk(start_bit == 1'b0, "R11 start while busy ignored", int'(start_bit), 0);
        chk(amux_sel == 3'd4, "R2 channel held while busy", int'(amux_sel), 4);
      end
    join
    keep = cyc;
    wait_to(keep + 140);
    chk(busy == 1'b0, "R11 no second conversion", int'(busy), 0);
    chk(rd_result() == 777, "R11 result unchanged", rd_result(), 777);

    // Standby aborts a running conversion and blocks starts
    chan_sel = 4'd6;
    psc_sel  = 2'd0;
    start_pulse(0, e0);
    wait_to(e0 + 50);
    @(negedge clk); standby = 1'b1;
    @(posedge clk); #1;
    wait_to(cyc + 1);
    chk(busy == 1'b0, "R8 standby aborts", int'(busy), 0);
    start_pulse(0, e0);
    chk(start_bit == 1'b0, "R8 start ignored in standby", int'(start_bit), 0);
    wait_to(e0 + 150);
    chk(done_flag == 1'b0, "R8 no flag after abort", int'(done_flag), 0);
    chk(rd_result() == 777, "R8 result kept", rd_result(), 777);
    @(negedge clk); standby = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk(sb_q.size() == 0, "R4 all completions seen", sb_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule